// File: doc/BRIEF.md
# Indirect-Addressed Serial Controller Port

This block is the host-side register interface of a single-channel serial communications controller. A byte-wide bus reaches it through two ports: a control port and a data port. Every channel register is reached indirectly. A first control write loads a register pointer. A second control write stores a byte into the register that the pointer selects. A control write with the value 0x10, made while no pointer is pending, is a command that clears the external/status interrupt flag.

The block holds a sixteen-entry channel register file. It decodes the command register and builds a composite status byte. It runs a simplified transmit path: an accepted byte marks the transmitter empty and all-sent, and can loop back into the receive data register. One registered interrupt line is driven by two sources, transmit and external/status, with transmit taking precedence. A two-bit code reports which source is currently requesting.

Top module: `ser_ctl_port`

## Requirements
- R1: Address value 1 is the control port and address value 3 is the data port. A read at address 0 or 2 returns 0x00, and a write there changes no state.
- R2: With no pointer pending, a control write whose bits [7:4] are zero loads bits [3:0] as the pointer and opens a write phase. The next control write stores the whole byte in the pointed register and closes the phase. A control write with bits [7:4] nonzero, other than 0x10, is ignored while no pointer is pending.
- R3: With no pointer pending, a control write of 0x10 clears the external/status pending flag. It leaves the phase idle, so the next control write is again taken as a pointer.
- R4: A control read during a write phase returns the pointed register and closes the phase. A control read with no pointer pending forces the pointer to 0 and returns the status byte.
- R5: Register 0 reads as the status byte: bit 6 is transmit underrun, bit 4 is sync hunt, and bits 2 (transmitter empty) and 0 (receive available) come from the stored register 0 value. All other bits read 0. Register 10 always reads 0x00, and every other register reads back its stored byte.
- R6: A write to register 0 decodes bits [5:3] as a command. Code 2 clears sync hunt, code 5 clears the transmit pending flag, and any other code has no effect on the flags.
- R7: Register 1 bit 0 enables external/status interrupts and bit 1 enables transmit interrupts. Register 3 bit 4 sets sync hunt. Register 5 bit 3 enables the transmitter and, when set, also sets status bit 2.
- R8: Register 9 bit 3 is the master interrupt enable. A write with bits [7:6] = 01 resets the channel: all sixteen registers, all flags and the receive data are cleared, underrun is left set, and the master enable keeps the written bit 3. A write with bits [7:6] = 11 does the same and also clears the master enable.
- R9: A data-port write is ignored unless the transmitter is enabled. An accepted write sets status bit 2, register 1 bit 0, underrun and transmit pending. When register 14 bit 4 is set, it also copies the byte into the receive data register (read at the data port) and sets status bit 0.
- R10: While the master enable is set, an enabled pending transmit source requests with code 1. Failing that, an enabled pending external/status source requests with code 2. With no request the code is 0. The line and the code are registered one cycle after the state that causes them.
- R11: A one-cycle pulse on `ext_evt` sets the external/status pending flag. A clear by 0x10 in the same cycle wins.
- R12: After reset the status byte reads 0x40, every register reads 0x00, the receive data is 0x00, the master enable is off and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset, equivalent to a full reset |
| bus_addr | input | 2 | Port select: 1 control, 3 data |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe cycle |
| ext_evt | input | 1 | External/status event pulse |
| irq | output | 1 | Registered interrupt request |
| irq_kind | output | 2 | Requesting source: 0 none, 1 transmit, 2 external/status |

## Verification
The assertions check on every cycle the properties that follow from a single strobe. Any control read leaves the phase idle. The 0x10 command empties the external flag without opening a phase. A data write with the transmitter off leaves the receive data and transmit flag alone, and an accepted one raises underrun and transmit pending. The interrupt line never rises without the master enable of the previous cycle, and it always agrees with the source code. The directed scenarios are the only way to show the multi-write behaviour: readback through the pointer, the composed status values, the command codes, the loopback, the difference between a channel reset and a full reset, and the transmit-over-external precedence as sources come and go.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NREGS  = 16;

    localparam logic [1:0] OFS_CTL  = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd3;

    localparam int REG_CMD  = 0;
    localparam int REG_IEN  = 1;
    localparam int REG_RXC  = 3;
    localparam int REG_TXC  = 5;
    localparam int REG_MIC  = 9;
    localparam int REG_ZERO = 10;
    localparam int REG_MISC = 14;

    localparam logic [2:0] CMD_CLR_HUNT = 3'd2;
    localparam logic [2:0] CMD_ACK_TX   = 3'd5;
    localparam logic [7:0] CLR_EXT_CODE = 8'h10;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'd0,
        IRQ_TX   = 2'd1,
        IRQ_EXT  = 2'd2
    } irq_kind_e;

    typedef struct packed {
        logic underrun;
        logic hunt;
        logic tx_en;
        logic tx_ie;
        logic ext_ie;
        logic tx_pend;
        logic ext_pend;
    } chan_flags_t;

    function automatic logic [7:0] compose_status(input logic underrun,
                                                  input logic hunt,
                                                  input logic [7:0] stored);
        compose_status = {1'b0, underrun, 1'b0, hunt, 1'b0, stored[2], 1'b0, stored[0]};
    endfunction

endpackage

// File: rtl/ser_ctl_access.sv
module ser_ctl_access
    import ser_ctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              clr_ext,
    output logic              in_write
);
    phase_e            phase;
    logic [IDX_W-1:0]  ptr;
    logic              ptr_load;

    always_comb begin
        reg_we   = ctl_wr && (phase == PH_WRITE);
        reg_idx  = ptr;
        rd_idx   = (phase == PH_WRITE) ? ptr : '0;
        ptr_load = ctl_wr && (phase == PH_IDLE) && (wdata[DATA_W-1:IDX_W] == '0);
        clr_ext  = ctl_wr && (phase == PH_IDLE) && (wdata == DATA_W'(CLR_EXT_CODE));
        in_write = (phase == PH_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            ptr   <= '0;
        end else if (ctl_wr) begin
            if (phase == PH_WRITE) begin
                phase <= PH_IDLE;
            end else if (ptr_load) begin
                ptr   <= wdata[IDX_W-1:0];
                phase <= PH_WRITE;
            end
        end else if (ctl_rd) begin
            if (phase == PH_WRITE) phase <= PH_IDLE;
            else                   ptr   <= '0;
        end
    end
endmodule

// File: rtl/ser_ctl_chan.sv
module ser_ctl_chan
    import ser_ctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              data_we,
    input  logic              clr_ext,
    input  logic              ext_evt,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] rx_data,
    output logic              underrun,
    output logic              tx_en,
    output logic              tx_ie,
    output logic              ext_ie,
    output logic              tx_pend,
    output logic              ext_pend,
    output logic              master
);
    logic [DATA_W-1:0] regs     [NREG];
    logic [DATA_W-1:0] regs_nxt [NREG];
    chan_flags_t       fl;
    logic wr_cmd, wr_ien, wr_rxc, wr_txc, wr_mic;
    logic chan_rst, full_rst, accept, loop_on;

    always_comb begin
        wr_cmd   = reg_we && (reg_idx == IDX_W'(REG_CMD));
        wr_ien   = reg_we && (reg_idx == IDX_W'(REG_IEN));
        wr_rxc   = reg_we && (reg_idx == IDX_W'(REG_RXC));
        wr_txc   = reg_we && (reg_idx == IDX_W'(REG_TXC));
        wr_mic   = reg_we && (reg_idx == IDX_W'(REG_MIC));
        chan_rst = wr_mic && wdata[6];
        full_rst = wr_mic && (wdata[7:6] == 2'b11);
        accept   = data_we && fl.tx_en;
        loop_on  = regs[REG_MISC][4];
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_nxt[i] = regs[i];
        if (reg_we) regs_nxt[reg_idx] = wdata;
        if (wr_txc && wdata[3]) regs_nxt[REG_CMD][2] = 1'b1;
        if (accept) begin
            regs_nxt[REG_CMD][2] = 1'b1;
            regs_nxt[REG_IEN][0] = 1'b1;
            if (loop_on) regs_nxt[REG_CMD][0] = 1'b1;
        end
        if (chan_rst) begin
            for (int i = 0; i < NREG; i++) regs_nxt[i] = '0;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs[g] <= '0;
            else     regs[g] <= regs_nxt[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            fl          <= '0;
            fl.underrun <= 1'b1;
            rx_data     <= '0;
        end else begin
            if (wr_cmd) begin
                case (wdata[5:3])
                    CMD_CLR_HUNT: fl.hunt    <= 1'b0;
                    CMD_ACK_TX:   fl.tx_pend <= 1'b0;
                    default: ;
                endcase
            end
            if (wr_ien) begin
                fl.ext_ie <= wdata[0];
                fl.tx_ie  <= wdata[1];
            end
            if (wr_rxc) fl.hunt  <= wdata[4];
            if (wr_txc) fl.tx_en <= wdata[3];
            if (accept) begin
                fl.underrun <= 1'b1;
                fl.tx_pend  <= 1'b1;
                if (loop_on) rx_data <= wdata;
            end
            if (clr_ext)      fl.ext_pend <= 1'b0;
            else if (ext_evt) fl.ext_pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || full_rst) master <= 1'b0;
        else if (wr_mic)     master <= wdata[3];
    end

    always_comb begin
        if (rd_idx == IDX_W'(REG_CMD))
            rd_val = DATA_W'(compose_status(fl.underrun, fl.hunt, regs[REG_CMD][7:0]));
        else if (rd_idx == IDX_W'(REG_ZERO))
            rd_val = '0;
        else
            rd_val = regs[rd_idx];
    end

    assign underrun = fl.underrun;
    assign tx_en    = fl.tx_en;
    assign tx_ie    = fl.tx_ie;
    assign ext_ie   = fl.ext_ie;
    assign tx_pend  = fl.tx_pend;
    assign ext_pend = fl.ext_pend;
endmodule

// File: rtl/ser_ctl_irq.sv
module ser_ctl_irq
    import ser_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      master,
    input  logic      tx_ie,
    input  logic      tx_pend,
    input  logic      ext_ie,
    input  logic      ext_pend,
    output logic      irq,
    output irq_kind_e kind
);
    irq_kind_e req;

    always_comb begin
        if (master && tx_ie && tx_pend)        req = IRQ_TX;
        else if (master && ext_ie && ext_pend) req = IRQ_EXT;
        else                                   req = IRQ_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind <= IRQ_NONE;
            irq  <= 1'b0;
        end else if (req != kind) begin
            kind <= req;
            irq  <= (req != IRQ_NONE);
        end
    end
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
    import ser_ctl_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int NREG   = NREGS,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_evt,
    output logic              irq,
    output logic [1:0]        irq_kind
);
    logic              ctl_wr, ctl_rd, data_wr;
    logic              reg_we, clr_ext, in_write;
    logic [IDX_W-1:0]  reg_idx, rd_idx;
    logic [DATA_W-1:0] rd_val, rx_data;
    logic              underrun, tx_en, tx_ie, ext_ie, tx_pend, ext_pend, master;
    irq_kind_e         kind;

    assign ctl_wr  = bus_wr && (bus_addr == OFS_CTL);
    assign ctl_rd  = bus_rd && (bus_addr == OFS_CTL);
    assign data_wr = bus_wr && (bus_addr == OFS_DATA);

    ser_ctl_access #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_access (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .wdata(bus_wdata),
        .reg_we(reg_we), .reg_idx(reg_idx), .rd_idx(rd_idx), .clr_ext(clr_ext),
        .in_write(in_write)
    );

    ser_ctl_chan #(.DATA_W(DATA_W), .NREG(NREG)) u_chan (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .rd_idx(rd_idx),
        .wdata(bus_wdata), .data_we(data_wr), .clr_ext(clr_ext), .ext_evt(ext_evt),
        .rd_val(rd_val), .rx_data(rx_data), .underrun(underrun), .tx_en(tx_en),
        .tx_ie(tx_ie), .ext_ie(ext_ie), .tx_pend(tx_pend), .ext_pend(ext_pend),
        .master(master)
    );

    ser_ctl_irq u_irq (
        .clk(clk), .rst(rst), .master(master), .tx_ie(tx_ie), .tx_pend(tx_pend),
        .ext_ie(ext_ie), .ext_pend(ext_pend), .irq(irq), .kind(kind)
    );

    assign irq_kind = kind;

    always_comb begin
        if (!bus_rd)                     bus_rdata = '0;
        else if (bus_addr == OFS_CTL)    bus_rdata = rd_val;
        else if (bus_addr == OFS_DATA)   bus_rdata = rx_data;
        else                             bus_rdata = '0;
    end
endmodule

// File: rtl/ser_ctl_chk.sv
module ser_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic       ctl_rd,
    input logic       data_wr,
    input logic [7:0] wdata,
    input logic       in_write,
    input logic       tx_en,
    input logic       underrun,
    input logic       tx_pend,
    input logic       ext_pend,
    input logic       master,
    input logic       irq,
    input logic [1:0] irq_kind,
    input logic [7:0] rx_data
);
    p_read_closes_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && !ctl_wr) |=> !in_write);

    p_ext_clear_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !in_write && wdata == 8'h10) |=> (!ext_pend && !in_write));

    p_data_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !tx_en && !ctl_wr) |=> ($stable(rx_data) && $stable(tx_pend)));

    p_data_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (data_wr && tx_en && !ctl_wr) |=> (underrun && tx_pend));

    p_irq_needs_master_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(master));

    p_irq_kind_agree_r10: assert property (@(posedge clk) disable iff (rst)
        (irq == (irq_kind != 2'd0)) && (irq_kind != 2'd3));
endmodule

bind ser_ctl_port ser_ctl_chk u_chk (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .data_wr(data_wr),
    .wdata(bus_wdata), .in_write(in_write), .tx_en(tx_en), .underrun(underrun),
    .tx_pend(tx_pend), .ext_pend(ext_pend), .master(master), .irq(irq),
    .irq_kind(irq_kind), .rx_data(rx_data)
);

// File: tb/tb_ser_ctl_port.sv
`timescale 1ns/1ps
module tb_ser_ctl_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_evt = 1'b0;
    logic       irq;
    logic [1:0] irq_kind;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ser_ctl_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_evt(ext_evt),
        .irq(irq), .irq_kind(irq_kind)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic r, input logic [1:0] a,
                       input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        #1 q = bus_rdata;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic cw(input logic [7:0] d);
        logic [7:0] q;
        bus(1'b1, 1'b0, 2'd1, d, q);
    endtask
    task automatic cr(output logic [7:0] q);
        bus(1'b0, 1'b1, 2'd1, 8'h00, q);
    endtask
    task automatic dw(input logic [7:0] d);
        logic [7:0] q;
        bus(1'b1, 1'b0, 2'd3, d, q);
    endtask
    task automatic dr(output logic [7:0] q);
        bus(1'b0, 1'b1, 2'd3, 8'h00, q);
    endtask
    task automatic wreg(input logic [3:0] i, input logic [7:0] d);
        cw({4'h0, i});
        cw(d);
    endtask
    task automatic rreg(input logic [3:0] i, output logic [7:0] q);
        cw({4'h0, i});
        cr(q);
    endtask
    task automatic settle();
        repeat (2) @(posedge clk);
        #1;
    endtask
    task automatic pulse_ext();
        @(negedge clk) ext_evt = 1'b1;
        @(posedge clk);
        #1 ext_evt = 1'b0;
    endtask
    task automatic full_reset();
        wreg(4'd9, 8'hC0);
    endtask

    task automatic t_reset();
        logic [7:0] q;
        chk("R12", "irq after reset", {7'd0, irq}, 8'h00);
        chk("R12", "kind after reset", {6'd0, irq_kind}, 8'h00);
        cr(q);  chk("R12", "status after reset", q, 8'h40);
        rreg(4'd1, q); chk("R12", "reg1 after reset", q, 8'h00);
        dr(q);  chk("R12", "rx data after reset", q, 8'h00);
    endtask

    task automatic t_pointer();
        logic [7:0] q;
        full_reset();
        wreg(4'd6, 8'hA5);
        rreg(4'd6, q); chk("R2", "reg6 readback", q, 8'hA5);
        wreg(4'd15, 8'h3C);
        rreg(4'd15, q); chk("R2", "reg15 readback", q, 8'h3C);
        cw(8'h26); cw(8'h06); cw(8'h5B);
        rreg(4'd6, q); chk("R2", "nonzero-nibble write ignored in idle", q, 8'h5B);
        cw(8'h06); cr(q); chk("R4", "write-phase read returns pointed reg", q, 8'h5B);
        cr(q); chk("R4", "idle read returns status", q, 8'h40);
    endtask

    task automatic t_status();
        logic [7:0] q;
        full_reset();
        wreg(4'd3, 8'h10);
        cr(q); chk("R7", "hunt set via reg3 bit4", q, 8'h50);
        rreg(4'd3, q); chk("R5", "reg3 readback", q, 8'h10);
        wreg(4'd5, 8'h08);
        cr(q); chk("R7", "tx enable sets status bit2", q, 8'h54);
        wreg(4'd10, 8'hFF);
        rreg(4'd10, q); chk("R5", "reg10 reads zero", q, 8'h00);
    endtask

    task automatic t_command();
        logic [7:0] q;
        full_reset();
        wreg(4'd3, 8'h10);
        wreg(4'd0, 8'h00);
        cr(q); chk("R6", "code 0 leaves hunt", q, 8'h50);
        wreg(4'd0, 8'h10);
        cr(q); chk("R6", "code 2 clears hunt", q, 8'h40);
    endtask

    task automatic t_data();
        logic [7:0] q;
        full_reset();
        dw(8'h77);
        dr(q); chk("R9", "disabled write ignored rx", q, 8'h00);
        cr(q); chk("R9", "disabled write ignored status", q, 8'h40);
        wreg(4'd5, 8'h08);
        wreg(4'd14, 8'h10);
        dw(8'h5A);
        dr(q); chk("R9", "loopback rx data", q, 8'h5A);
        cr(q); chk("R9", "status after loopback write", q, 8'h45);
        rreg(4'd1, q); chk("R9", "all-sent bit", q, 8'h01);
        wreg(4'd14, 8'h00);
        dw(8'h33);
        dr(q); chk("R9", "no loopback keeps rx", q, 8'h5A);
        bus(1'b0, 1'b1, 2'd0, 8'h00, q); chk("R1", "offset 0 reads zero", q, 8'h00);
        bus(1'b0, 1'b1, 2'd2, 8'h00, q); chk("R1", "offset 2 reads zero", q, 8'h00);
        bus(1'b1, 1'b0, 2'd2, 8'h07, q);
        rreg(4'd7, q); chk("R1", "offset 2 write no effect", q, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] q;
        full_reset();
        wreg(4'd5, 8'h08);
        wreg(4'd1, 8'h03);
        pulse_ext();
        settle(); chk("R10", "no irq without master", {7'd0, irq}, 8'h00);
        wreg(4'd9, 8'h08);
        settle(); chk("R11", "ext event requests", {6'd0, irq_kind}, 8'h02);
        chk("R10", "irq line high", {7'd0, irq}, 8'h01);
        dw(8'h11);
        settle(); chk("R10", "tx has priority", {6'd0, irq_kind}, 8'h01);
        wreg(4'd0, 8'h28);
        settle(); chk("R6", "code 5 clears tx pending", {6'd0, irq_kind}, 8'h02);
        cw(8'h10);
        settle(); chk("R3", "0x10 clears ext pending", {7'd0, irq}, 8'h00);
        wreg(4'd7, 8'h99);
        rreg(4'd7, q); chk("R3", "phase stays idle after 0x10", q, 8'h99);
        wreg(4'd9, 8'h48);
        rreg(4'd5, q); chk("R8", "channel reset clears regs", q, 8'h00);
        rreg(4'd7, q); chk("R8", "channel reset clears reg7", q, 8'h00);
        cr(q); chk("R8", "status after channel reset", q, 8'h40);
        wreg(4'd5, 8'h08);
        wreg(4'd1, 8'h02);
        dw(8'h01);
        settle(); chk("R8", "master kept over channel reset", {6'd0, irq_kind}, 8'h01);
        full_reset();
        settle(); chk("R8", "full reset drops irq", {7'd0, irq}, 8'h00);
        wreg(4'd5, 8'h08);
        wreg(4'd1, 8'h02);
        dw(8'h01);
        settle(); chk("R8", "master cleared by full reset", {7'd0, irq}, 8'h00);
        wreg(4'd9, 8'h08);
        settle(); chk("R10", "master re-enabled tx irq", {6'd0, irq_kind}, 8'h01);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_pointer();
        t_status();
        t_command();
        t_data();
        t_irq();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule